// File: doc/BRIEF.md
# Virtualization-Aware Interrupt Selector

This block decides, once per cycle, whether a hart should take an asynchronous interrupt, and which cause wins. It combines the raw pending and enable vectors with the supervisor delegation mask, the current privilege level and the global interrupt-enable bits. When the hypervisor extension is present and the hart runs in virtual mode, interrupts that belong to the host supervisor level pre-empt anything the guest could see, and the block flags that the trap must go to the hypervisor level.

In virtual mode the guest never sees the three virtual-supervisor interrupt lines in their own slots. They are moved down by one position onto the matching supervisor slots before the ordinary delegation and enable rules are applied. The block only chooses and ranks causes. Trap entry, register updates and synchronous exceptions belong to neighbouring logic. With `OUT_REG` set, the three outputs are registered and follow the inputs by one clock.

Top module: `irqsel_top`

## Requirements
- R1: The host-level candidate vector is `pend_i & en_i` with bits 2, 6 and 10 (virtual-supervisor software, timer and external) forced to zero. None of those three indices is ever reported as a cause.
- R2: When virtual mode is in effect, the guest candidate vector is `pend_i & en_i` limited to bits 2, 6 and 10 and shifted right by one. Bit 2 reports as cause 1, bit 6 as cause 5 and bit 10 as cause 9.
- R3: Undelegated causes are enabled when `priv_i` is below machine (encoding U=0, S=1, reserved=2, M=3), or when `priv_i`=3 and `m_gie_i`=1.
- R4: Delegated causes are enabled when `priv_i`=0, or when `priv_i`=1 and `s_gie_i`=1. `priv_i`=2 enables no delegated cause.
- R5: In virtual mode, any host-level candidate bit passes when `priv_i`=0, or when `priv_i`=1 and `hs_gie_i`=1. Such a bit wins before any guest cause, whatever the delegation mask says, and sets `irq_to_hyp_o`.
- R6: Otherwise a bit qualifies when it is set in the candidate vector and is either undelegated under R3 or delegated under R4. The candidate vector is the host vector outside virtual mode and the guest vector inside it. `irq_to_hyp_o` is 0 in this case.
- R7: Among qualifying bits, the lowest index wins.
- R8: When `hext_i`=0, `virt_i` has no effect and `irq_to_hyp_o` stays 0.
- R9: When no bit qualifies, `irq_valid_o`=0, `irq_cause_o`=0 and `irq_to_hyp_o`=0.
- R10: With `OUT_REG`=1, the outputs reflect the inputs sampled at the previous rising clock edge, and all three are 0 while `rst_n` is low.
- R11: `XLEN` may be 32 or 64. The cause output is `$clog2(XLEN)` bits wide and bit `XLEN-1` can be reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | XLEN | Raw interrupt pending vector |
| en_i | input | XLEN | Per-cause interrupt enable vector |
| deleg_i | input | XLEN | Supervisor delegation mask, 1 = delegated |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Hart is in virtual mode |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable of the active context |
| hs_gie_i | input | 1 | Supervisor global interrupt enable of the host context |
| hext_i | input | 1 | Hypervisor extension present |
| irq_valid_o | output | 1 | An interrupt should be taken |
| irq_cause_o | output | $clog2(XLEN) | Index of the winning cause |
| irq_to_hyp_o | output | 1 | Trap must be taken at hypervisor level |

## Verification
The bench targets the virtual-mode corners. In the first, a host cause with a higher index must beat a lower guest cause; a design that ranked the two vectors together would report the guest cause and leave the hypervisor flag low. In the second, with the host enable off, a virtual-supervisor line must come out one slot lower; an unshifted design would report 2, 6 or 10, or nothing. Other tests clear `hext_i` while `virt_i` is high, where a design that still honoured virtual mode would raise the hypervisor flag. They also exercise the reserved privilege level, where a delegated cause must stay blocked, and the top bit of the vector, where a truncated priority encoder would misreport.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // slots of the virtual-supervisor lines; each maps to the slot just below
  localparam int VS_SOFT_BIT = 2;
  localparam int VS_TIME_BIT = 6;
  localparam int VS_EXT_BIT  = 10;

  function automatic logic [63:0] vs_mask64();
    logic [63:0] m;
    m = '0;
    m[VS_SOFT_BIT] = 1'b1;
    m[VS_TIME_BIT] = 1'b1;
    m[VS_EXT_BIT]  = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqsel_split.sv
module irqsel_split
  import irqsel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] en_i,
  output logic [XLEN-1:0] host_vec_o,
  output logic [XLEN-1:0] guest_vec_o
);
  localparam logic [63:0] VS_M64 = vs_mask64();
  localparam logic [XLEN-1:0] VS_M = VS_M64[XLEN-1:0];

  logic [XLEN-1:0] armed;

  always_comb begin
    armed       = pend_i & en_i;
    host_vec_o  = armed & ~VS_M;
    guest_vec_o = (armed & VS_M) >> 1;
  end
endmodule

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       m_gie_i,
  input  logic       s_gie_i,
  input  logic       hs_gie_i,
  output logic       m_en_o,
  output logic       s_en_o,
  output logic       hs_en_o
);
  priv_e lvl;

  always_comb begin
    lvl     = priv_e'(priv_i);
    m_en_o  = (lvl != PRIV_MACH) || m_gie_i;
    s_en_o  = (lvl == PRIV_USER) || ((lvl == PRIV_SUPV) && s_gie_i);
    hs_en_o = (lvl == PRIV_USER) || ((lvl == PRIV_SUPV) && hs_gie_i);
  end
endmodule

// File: rtl/irqsel_ctz.sv
module irqsel_ctz #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         vec_i,
  output logic                    any_o,
  output logic [$clog2(XLEN)-1:0] idx_o
);
  localparam int IW = $clog2(XLEN);

  always_comb begin
    idx_o = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [XLEN-1:0]         pend_i,
  input  logic [XLEN-1:0]         en_i,
  input  logic [XLEN-1:0]         deleg_i,
  input  logic [1:0]              priv_i,
  input  logic                    virt_i,
  input  logic                    m_gie_i,
  input  logic                    s_gie_i,
  input  logic                    hs_gie_i,
  input  logic                    hext_i,
  output logic                    irq_valid_o,
  output logic [$clog2(XLEN)-1:0] irq_cause_o,
  output logic                    irq_to_hyp_o
);
  localparam int IW = $clog2(XLEN);

  logic [XLEN-1:0] host_vec, guest_vec, cand_vec, qual_vec, hyp_vec;
  logic            m_en, s_en, hs_en, virt_eff;
  logic            hyp_any, g_any;
  logic [IW-1:0]   hyp_idx, g_idx;
  logic            nx_valid, nx_hyp;
  logic [IW-1:0]   nx_cause;

  irqsel_split #(.XLEN(XLEN)) u_split (
    .pend_i      (pend_i),
    .en_i        (en_i),
    .host_vec_o  (host_vec),
    .guest_vec_o (guest_vec)
  );

  irqsel_gate u_gate (
    .priv_i   (priv_i),
    .m_gie_i  (m_gie_i),
    .s_gie_i  (s_gie_i),
    .hs_gie_i (hs_gie_i),
    .m_en_o   (m_en),
    .s_en_o   (s_en),
    .hs_en_o  (hs_en)
  );

  always_comb begin
    virt_eff = virt_i & hext_i;
    hyp_vec  = host_vec & {XLEN{hs_en & virt_eff}};
    cand_vec = virt_eff ? guest_vec : host_vec;
    qual_vec = (cand_vec & ~deleg_i & {XLEN{m_en}}) |
               (cand_vec &  deleg_i & {XLEN{s_en}});
  end

  irqsel_ctz #(.XLEN(XLEN)) u_ctz_hyp (
    .vec_i (hyp_vec),
    .any_o (hyp_any),
    .idx_o (hyp_idx)
  );

  irqsel_ctz #(.XLEN(XLEN)) u_ctz_guest (
    .vec_i (qual_vec),
    .any_o (g_any),
    .idx_o (g_idx)
  );

  always_comb begin
    nx_valid = 1'b0;
    nx_hyp   = 1'b0;
    nx_cause = '0;
    if (hyp_any) begin
      nx_valid = 1'b1;
      nx_hyp   = 1'b1;
      nx_cause = hyp_idx;
    end else if (g_any) begin
      nx_valid = 1'b1;
      nx_cause = g_idx;
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          irq_valid_o  <= 1'b0;
          irq_cause_o  <= '0;
          irq_to_hyp_o <= 1'b0;
        end else begin
          irq_valid_o  <= nx_valid;
          irq_cause_o  <= nx_cause;
          irq_to_hyp_o <= nx_hyp;
        end
      end
    end else begin : g_comb
      assign irq_valid_o  = nx_valid;
      assign irq_cause_o  = nx_cause;
      assign irq_to_hyp_o = nx_hyp;
    end
  endgenerate
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [XLEN-1:0]         pend_i,
  input logic [XLEN-1:0]         en_i,
  input logic                    virt_i,
  input logic                    hext_i,
  input logic                    irq_valid_o,
  input logic [$clog2(XLEN)-1:0] irq_cause_o,
  input logic                    irq_to_hyp_o
);
  logic [XLEN-1:0] pe_q;
  logic            virt_q, hext_q;
  logic [XLEN-1:0] o_pe;
  logic            o_virt, o_hext, guest_mode, vs_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q   <= '0;
      virt_q <= 1'b0;
      hext_q <= 1'b0;
    end else begin
      pe_q   <= pend_i & en_i;
      virt_q <= virt_i;
      hext_q <= hext_i;
    end
  end

  always_comb begin
    o_pe       = OUT_REG ? pe_q   : (pend_i & en_i);
    o_virt     = OUT_REG ? virt_q : virt_i;
    o_hext     = OUT_REG ? hext_q : hext_i;
    guest_mode = o_virt && o_hext && !irq_to_hyp_o;
    vs_hit     = (irq_cause_o == 1 && o_pe[2]) ||
                 (irq_cause_o == 5 && o_pe[6]) ||
                 (irq_cause_o == 9 && o_pe[10]);
  end

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid_o |-> (irq_cause_o == 0 && !irq_to_hyp_o));

  a_r8_no_hyp_without_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !o_hext |-> !irq_to_hyp_o);

  a_r5_hyp_needs_virt: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_hyp_o |-> (irq_valid_o && o_virt && o_hext));

  a_r1_vs_slot_never_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_cause_o != 2 && irq_cause_o != 6 && irq_cause_o != 10));

  a_r7_cause_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !guest_mode) |-> o_pe[irq_cause_o]);

  a_r2_guest_from_vs: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && guest_mode) |-> vs_hit);
endmodule

bind irqsel_top irqsel_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pend_i       (pend_i),
  .en_i         (en_i),
  .virt_i       (virt_i),
  .hext_i       (hext_i),
  .irq_valid_o  (irq_valid_o),
  .irq_cause_o  (irq_cause_o),
  .irq_to_hyp_o (irq_to_hyp_o)
);

// File: tb/irqsel_top_tb.sv
`timescale 1ns/1ps
module irqsel_top_tb;
  localparam int XLEN = 64;
  localparam int IW   = $clog2(XLEN);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [XLEN-1:0] pend = '0, en = '0, deleg = '0;
  logic [1:0]      priv = 2'd3;
  logic            virt = 0, mgie = 0, sgie = 0, hsgie = 0, hext = 0;
  logic            v_o, h_o;
  logic [IW-1:0]   c_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic          v;
    logic [IW-1:0] c;
    logic          h;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  irqsel_top #(.XLEN(XLEN), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .virt_i(virt), .m_gie_i(mgie), .s_gie_i(sgie),
    .hs_gie_i(hsgie), .hext_i(hext),
    .irq_valid_o(v_o), .irq_cause_o(c_o), .irq_to_hyp_o(h_o)
  );

  task automatic check(input logic v, input logic [IW-1:0] c, input logic h, input string tag);
    n_chk++;
    if (v_o !== v || c_o !== c || h_o !== h) begin
      n_fail++;
      $display("FAIL %s: got v=%0b c=%0d h=%0b expected v=%0b c=%0d h=%0b",
               tag, v_o, c_o, h_o, v, c, h);
    end
  endtask

  // Reference model written from the requirement list
  task automatic model(output exp_t e);
    logic [XLEN-1:0] vsm, pe, host, guest, cand, q, hq;
    logic m_en, s_en, hs_en, ve;
    vsm = '0; vsm[2] = 1; vsm[6] = 1; vsm[10] = 1;
    pe = pend & en;
    host = pe & ~vsm;
    guest = (pe & vsm) >> 1;
    ve = virt & hext;
    m_en  = (priv != 2'd3) || mgie;
    s_en  = (priv == 2'd0) || (priv == 2'd1 && sgie);
    hs_en = (priv == 2'd0) || (priv == 2'd1 && hsgie);
    hq = (ve && hs_en) ? host : '0;
    cand = ve ? guest : host;
    q = (cand & ~deleg & {XLEN{m_en}}) | (cand & deleg & {XLEN{s_en}});
    e.v = 0; e.c = '0; e.h = 0;
    if (hq != 0) begin
      e.v = 1; e.h = 1;
      for (int i = XLEN - 1; i >= 0; i--) if (hq[i]) e.c = IW'(i);
    end else if (q != 0) begin
      e.v = 1;
      for (int i = XLEN - 1; i >= 0; i--) if (q[i]) e.c = IW'(i);
    end
  endtask

  task automatic drv(input logic [XLEN-1:0] p, input logic [XLEN-1:0] e,
                     input logic [XLEN-1:0] d, input logic [1:0] pr,
                     input logic vi, input logic mg, input logic sg,
                     input logic hg, input logic hx, input string tag);
    exp_t x;
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pr; virt = vi;
    mgie = mg; sgie = sg; hsgie = hg; hext = hx;
    model(x);
    x.tag = tag;
    sb.push_back(x);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        check(x.v, x.c, x.h, x.tag);
      end
    end
  end

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic [XLEN-1:0] ALL = '1;

  initial begin : stim
    // R10: outputs cleared while in reset
    pend = ALL; en = ALL; mgie = 1;
    repeat (3) @(posedge clk);
    #1 check(1'b0, '0, 1'b0, "R10 reset");
    @(negedge clk);
    rst_n = 1'b1;
    pend = '0; en = '0; mgie = 0;
    @(posedge clk); #1 check(1'b0, '0, 1'b0, "R9 idle after reset");

    // R10: one-cycle latency, output unchanged before the edge
    @(negedge clk);
    pend = 64'h80; en = 64'h80; priv = 2'd3; mgie = 1;
    #1 check(1'b0, '0, 1'b0, "R10 no change before edge");
    @(posedge clk); #1 check(1'b1, IW'(7), 1'b0, "R10 registered after edge");

    drv(64'h0, ALL, 0, 2'd3, 0, 1, 1, 1, 1, "R9 nothing pending");
    drv(64'h880, ALL, 0, 2'd3, 0, 1, 0, 0, 1, "R3_R7 M mode lowest of 7,11");
    drv(64'h880, ALL, 0, 2'd3, 0, 0, 0, 0, 1, "R3 M mode gie off");
    drv(64'h8, ALL, 0, 2'd0, 0, 0, 0, 0, 1, "R3 U mode ignores gie");
    drv(64'h20, ALL, 64'h20, 2'd1, 0, 1, 0, 0, 1, "R4 S mode delegated sie off");
    drv(64'h20, ALL, 64'h20, 2'd1, 0, 0, 1, 0, 1, "R4 S mode delegated sie on");
    drv(64'hA00, ALL, 64'h200, 2'd1, 0, 0, 0, 0, 1, "R6 undelegated wins in S");
    drv(64'h2, ALL, 64'h2, 2'd2, 0, 1, 1, 1, 1, "R4 reserved priv blocks delegated");
    drv(64'h4, ALL, 0, 2'd3, 0, 1, 1, 1, 1, "R1 vs line masked outside virt");
    drv(64'h444, ALL, 0, 2'd3, 0, 1, 1, 1, 0, "R1 all vs lines masked");
    drv(64'h40, ALL, 64'h20, 2'd1, 1, 0, 1, 0, 1, "R2 vs timer to cause 5");
    drv(64'h404, ALL, 64'h202, 2'd1, 1, 0, 1, 0, 1, "R2 vs soft and ext lowest 1");
    drv(64'h204, ALL, 64'h2, 2'd1, 1, 0, 1, 1, 1, "R5 host 9 preempts guest 1");
    drv(64'h800, ALL, ALL, 2'd0, 1, 0, 0, 0, 1, "R5 U mode host wins ignoring deleg");
    drv(64'h600, ALL, 64'h200, 2'd1, 1, 0, 1, 0, 1, "R6 guest ignores host bit 9");
    drv(64'h48, ALL, 0, 2'd0, 1, 0, 0, 0, 0, "R8 no ext virt ignored");
    drv(64'h40, ALL, 0, 2'd0, 1, 0, 0, 1, 0, "R8 no ext vs masked");
    drv(64'h8000_0000_0000_0000, ALL, 0, 2'd3, 0, 1, 0, 0, 1, "R11 top bit");
    drv(64'h8000_0000_0000_0001, ALL, 0, 2'd3, 0, 1, 0, 0, 1, "R7 bit 0 beats top");
    drv(64'h880, 64'h800, 0, 2'd3, 0, 1, 0, 0, 1, "R7 enable filters 7");
    drv(64'h0, ALL, 0, 2'd3, 0, 1, 0, 0, 1, "R9 back to idle");

    repeat (3) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule